// File: doc/BRIEF.md
# Audio Sample Fetch and Playback Channel

This block is one playback voice. It reads 16-bit words of sample data from memory and sends them out as scaled signed samples at a rate that software sets. Software programs five settings through a small write port: an 18-bit word start location split into a 3-bit upper part and a 15-bit lower part, a block length in words, a sample period, and a volume. The channel keeps its own working address and word count. These are loaded from the location and length settings and are never written back to them. When a block ends, the working copies reload, so the block repeats without any help from software.

Each word holds two 8-bit signed samples, and the high byte plays first. A down-counter advances on a timebase tick, and each time it expires the next byte is scaled by the volume and presented. Word fetches go out on a request channel with a valid/ready handshake. The channel holds `mem_req_valid` and `mem_req_addr` unchanged until `mem_req_ready` is seen high at a clock edge. Memory answers each accepted request with one `mem_rsp_valid` pulse carrying the data. The channel always accepts a response and applies no back-pressure on that path. At most one request is outstanding at any time.

Top module: `aud_dma_channel`

## Requirements
- R1: After reset, and from the clock edge after `chan_en` is low, `sample_out` is 0. While the channel is disabled, `mem_req_valid` and `sample_strobe` stay low.
- R2: Selector 0 writes the upper location bits from `cfg_wdata[2:0]`. Selector 1 writes the lower bits from `cfg_wdata[14:0]`. The location is upper*32768 + lower. The clock edge that sees `chan_en` rise raises `mem_req_valid` with `mem_req_addr` equal to the location.
- R3: Each accepted request (valid and ready high at an edge) is followed by the next request at the address plus one, modulo 2^18, until the block ends.
- R4: Selector 2 sets the block length in words, and a value of 0 counts as 1. After a block's last word is accepted, the next request goes to the location again. `block_done` is high for exactly the one cycle after that acceptance. Playback never alters the location.
- R5: Selector 3 sets the period. Consecutive `sample_strobe` pulses are the period times the tick spacing in clock cycles apart, and a period below 124 acts as 124.
- R6: Within each fetched word, the sample from bits 15:8 is presented before the sample from bits 7:0. Words play in request order.
- R7: Selector 4 sets the volume. `sample_out` is the signed byte times V, where V is 64 if bit 6 is set and bits 5:0 otherwise. Bits 15:7 have no effect.
- R8: `mem_req_valid` for the next word is high in the cycle after the `sample_strobe` that presents a low byte.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address stay the same on the next cycle.
- R10: The period counter counts only cycles with `tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase enable for the period counter |
| chan_en | input | 1 | Channel enable; a rising edge starts a block |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 3 | Setting selector (0 loc upper, 1 loc lower, 2 length, 3 period, 4 volume) |
| cfg_wdata | input | 16 | Setting write data |
| mem_req_valid | output | 1 | Word fetch request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 18 | Word address of the request |
| mem_rsp_valid | input | 1 | Response data valid (one pulse per request) |
| mem_rsp_data | input | 16 | Fetched sample word |
| sample_out | output | 15 | Scaled signed sample |
| sample_strobe | output | 1 | One-cycle pulse when a new sample is presented |
| block_done | output | 1 | One-cycle pulse at the end of each block |

## Verification
The hardest case to reach is the block reload when it coincides with other edge conditions. These include a pointer crossing the top of the 18-bit space, a stalled request, a one-word block and a zero length. The stimulus gets there by placing the start location two words below the top of the address space with a five-word block, while ready is low two cycles out of three. Separate runs use lengths of one and zero. A full sweep of all 128 volume codes, with junk in the ignored upper bits, is rewritten after every sample. The expected product for each code is computed from the address-derived data pattern.

// File: rtl/aud_pkg.sv
package aud_pkg;
  typedef enum logic [2:0] {
    SEL_LOC_HI = 3'd0,
    SEL_LOC_LO = 3'd1,
    SEL_LEN    = 3'd2,
    SEL_PER    = 3'd3,
    SEL_VOL    = 3'd4
  } cfg_sel_e;

  localparam int VOL_W = 7;
  localparam int VOL_FULL = 64;
endpackage

// File: rtl/aud_regs.sv
module aud_regs
  import aud_pkg::*;
#(
  parameter int HI_W       = 3,
  parameter int LO_W       = 15,
  parameter int DATA_W     = 16,
  parameter int MIN_PERIOD = 124,
  localparam int ADDR_W    = HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] loc,
  output logic [DATA_W-1:0] len,
  output logic [DATA_W-1:0] per_eff,
  output logic [VOL_W-1:0]  vol_eff
);
  logic [HI_W-1:0]   loc_hi_r;
  logic [LO_W-1:0]   loc_lo_r;
  logic [DATA_W-1:0] len_r;
  logic [DATA_W-1:0] per_r;
  logic [VOL_W-1:0]  vol_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_hi_r <= '0;
      loc_lo_r <= '0;
      len_r    <= '0;
      per_r    <= DATA_W'(MIN_PERIOD);
      vol_r    <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_LOC_HI: loc_hi_r <= cfg_wdata[HI_W-1:0];
        SEL_LOC_LO: loc_lo_r <= cfg_wdata[LO_W-1:0];
        SEL_LEN:    len_r    <= cfg_wdata;
        SEL_PER:    per_r    <= cfg_wdata;
        SEL_VOL:    vol_r    <= cfg_wdata[VOL_W-1:0];
        default: ;
      endcase
    end
  end

  assign loc = {loc_hi_r, loc_lo_r};
  assign len = len_r;

  always_comb begin
    if (per_r < DATA_W'(MIN_PERIOD)) per_eff = DATA_W'(MIN_PERIOD);
    else                             per_eff = per_r;
  end

  always_comb begin
    if (vol_r[VOL_W-1]) vol_eff = VOL_W'(VOL_FULL);
    else                vol_eff = {1'b0, vol_r[VOL_W-2:0]};
  end
endmodule

// File: rtl/aud_timer.sv
module aud_timer #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              start,
  input  logic              tick,
  input  logic [DATA_W-1:0] period,
  output logic              expire
);
  logic [DATA_W-1:0] cnt;
  logic              ran_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      expire <= 1'b0;
      ran_q  <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (!run) begin
        ran_q <= 1'b0;
      end else if (start) begin
        cnt   <= period;
        ran_q <= 1'b1;
      end else if (tick) begin
        if (cnt <= DATA_W'(1)) begin
          cnt    <= period;
          expire <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R5
  cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ran_q |-> (cnt != '0));
endmodule

// File: rtl/aud_seq.sv
module aud_seq #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              start,
  input  logic              fetch,
  input  logic [ADDR_W-1:0] loc,
  input  logic [DATA_W-1:0] len,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              block_done
);
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] left;
  logic              accept;

  assign accept   = req_valid && req_ready;
  assign req_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr        <= '0;
      left       <= '0;
      req_valid  <= 1'b0;
      block_done <= 1'b0;
    end else begin
      block_done <= 1'b0;
      if (!run) begin
        req_valid <= 1'b0;
      end else if (start) begin
        ptr       <= loc;
        left      <= len;
        req_valid <= 1'b1;
      end else begin
        if (accept) begin
          req_valid <= 1'b0;
          if (left <= DATA_W'(1)) begin
            ptr        <= loc;
            left       <= len;
            block_done <= 1'b1;
          end else begin
            ptr  <= ptr + 1'b1;
            left <= left - 1'b1;
          end
        end
        if (fetch) req_valid <= 1'b1;
      end
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && run) |=> (req_valid && $stable(req_addr)));

  // R4
  done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |-> $past(req_valid && req_ready));
endmodule

// File: rtl/aud_out.sv
module aud_out
  import aud_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int SAMP_W = DATA_W / 2,
  localparam int OUT_W  = SAMP_W + VOL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic                    expire,
  input  logic                    rsp_valid,
  input  logic [DATA_W-1:0]       rsp_data,
  input  logic [VOL_W-1:0]        vol_eff,
  output logic signed [OUT_W-1:0] sample_out,
  output logic                    sample_strobe,
  output logic                    fetch
);
  logic [DATA_W-1:0] next_word;
  logic              next_full;
  logic [DATA_W-1:0] play_word;
  logic              on_low;

  function automatic logic signed [OUT_W-1:0] scale(input logic [SAMP_W-1:0] b,
                                                    input logic [VOL_W-1:0] v);
    logic signed [OUT_W:0] p;
    p = $signed({{(OUT_W+1-SAMP_W){b[SAMP_W-1]}}, b}) *
        $signed({{(OUT_W+1-VOL_W){1'b0}}, v});
    return p[OUT_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_word     <= '0;
      next_full     <= 1'b0;
      play_word     <= '0;
      on_low        <= 1'b0;
      sample_out    <= '0;
      sample_strobe <= 1'b0;
      fetch         <= 1'b0;
    end else begin
      sample_strobe <= 1'b0;
      fetch         <= 1'b0;
      if (!run) begin
        next_full  <= 1'b0;
        on_low     <= 1'b0;
        sample_out <= '0;
      end else begin
        if (expire) begin
          if (!on_low) begin
            if (next_full) begin
              play_word     <= next_word;
              next_full     <= 1'b0;
              sample_out    <= scale(next_word[DATA_W-1:SAMP_W], vol_eff);
              sample_strobe <= 1'b1;
              on_low        <= 1'b1;
            end
          end else begin
            sample_out    <= scale(play_word[SAMP_W-1:0], vol_eff);
            sample_strobe <= 1'b1;
            on_low        <= 1'b0;
            fetch         <= 1'b1;
          end
        end
        if (rsp_valid) begin
          next_word <= rsp_data;
          next_full <= 1'b1;
        end
      end
    end
  end

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sample_out == '0));

  // R5
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> !sample_strobe);
endmodule

// File: rtl/aud_dma_channel.sv
module aud_dma_channel
  import aud_pkg::*;
#(
  parameter int HI_W       = 3,
  parameter int LO_W       = 15,
  parameter int DATA_W     = 16,
  parameter int MIN_PERIOD = 124,
  localparam int ADDR_W    = HI_W + LO_W,
  localparam int OUT_W     = DATA_W / 2 + VOL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    chan_en,
  input  logic                    cfg_we,
  input  logic [2:0]              cfg_sel,
  input  logic [DATA_W-1:0]       cfg_wdata,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [ADDR_W-1:0]       mem_req_addr,
  input  logic                    mem_rsp_valid,
  input  logic [DATA_W-1:0]       mem_rsp_data,
  output logic signed [OUT_W-1:0] sample_out,
  output logic                    sample_strobe,
  output logic                    block_done
);
  logic [ADDR_W-1:0] loc;
  logic [DATA_W-1:0] len;
  logic [DATA_W-1:0] per_eff;
  logic [VOL_W-1:0]  vol_eff;
  logic              en_q;
  logic              start;
  logic              expire;
  logic              fetch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= chan_en;
  end

  assign start = chan_en && !en_q;

  aud_regs #(
    .HI_W(HI_W), .LO_W(LO_W), .DATA_W(DATA_W), .MIN_PERIOD(MIN_PERIOD)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .loc(loc), .len(len), .per_eff(per_eff),
    .vol_eff(vol_eff)
  );

  aud_timer #(.DATA_W(DATA_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(chan_en), .start(start), .tick(tick),
    .period(per_eff), .expire(expire)
  );

  aud_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(chan_en), .start(start), .fetch(fetch),
    .loc(loc), .len(len), .req_ready(mem_req_ready), .req_valid(mem_req_valid),
    .req_addr(mem_req_addr), .block_done(block_done)
  );

  aud_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .run(chan_en), .expire(expire),
    .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data), .vol_eff(vol_eff),
    .sample_out(sample_out), .sample_strobe(sample_strobe), .fetch(fetch)
  );

  // R2
  start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (mem_req_valid && mem_req_addr == $past(loc)));
endmodule

// File: tb/tb_aud_dma_channel.sv
module tb_aud_dma_channel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic chan_en = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic mem_req_valid;
  logic mem_req_ready = 1'b1;
  logic [17:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic signed [14:0] sample_out;
  logic sample_strobe;
  logic block_done;

  aud_dma_channel dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .chan_en(chan_en), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .sample_out(sample_out), .sample_strobe(sample_strobe), .block_done(block_done)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int m_loc = 0, m_len = 1, m_vol = 0, per_exp = 124, tdiv = 1, tph = 0;
  bit bp = 0;
  int q_ptr = 0, q_cnt = 1, paddr = 0, stall_addr = 0;
  bit pend = 0, done_exp = 0, stall_prev = 0;
  int s_ptr = 0, s_cnt = 1, s_word = 0, nstrb = 0, last_cyc = -1;
  bit s_lo = 0, fetch_exp = 0;

  function automatic int fw(int a);
    return (a * 40503 + 12345) & 16'hFFFF;
  endfunction
  function automatic int sx8(int b);
    return (b >= 128) ? b - 256 : b;
  endfunction
  function automatic int leff(int l);
    return (l == 0) ? 1 : l;
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wr(int sel, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int veff(int v);
    return ((v & 64) != 0) ? 64 : (v & 63);
  endfunction

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  // timebase tick
  initial begin
    forever begin
      @(negedge clk);
      if (tdiv <= 1) tick = 1'b1;
      else begin
        tick = (tph == 0);
        tph = (tph + 1) % tdiv;
      end
    end
  end

  // memory model with optional back-pressure
  initial begin
    forever begin
      @(negedge clk);
      if (!chan_en) begin
        pend = 0; done_exp = 0; stall_prev = 0; mem_rsp_valid = 1'b0;
      end else begin
        mem_rsp_valid = pend;
        if (pend) mem_rsp_data = 16'(fw(paddr));
        pend = 0;
        if (done_exp || block_done)
          chk(block_done == done_exp, "R4 block_done", int'(block_done), int'(done_exp));
        done_exp = 0;
        if (stall_prev)
          chk(mem_req_valid && int'(mem_req_addr) == stall_addr, "R9 held request",
              int'(mem_req_addr), stall_addr);
        stall_prev = 0;
        mem_req_ready = bp ? ((cyc % 3) == 0) : 1'b1;
        if (mem_req_valid && mem_req_ready) begin
          chk(int'(mem_req_addr) == q_ptr, "R3 request address", int'(mem_req_addr), q_ptr);
          pend = 1; paddr = q_ptr;
          if (q_cnt <= 1) begin
            q_ptr = m_loc; q_cnt = leff(m_len); done_exp = 1;
          end else begin
            q_ptr = (q_ptr + 1) % 262144; q_cnt--;
          end
        end else if (mem_req_valid) begin
          stall_prev = 1; stall_addr = int'(mem_req_addr);
        end
      end
    end
  end

  // sample checker
  initial begin
    forever begin
      @(negedge clk);
      if (fetch_exp) begin
        chk(mem_req_valid == 1'b1, "R8 fetch after low byte", int'(mem_req_valid), 1);
        fetch_exp = 0;
      end
      if (sample_strobe) begin
        int expv;
        nstrb++;
        if (last_cyc >= 0)
          chk(cyc - last_cyc == per_exp * tdiv, "R5 R10 strobe spacing",
              cyc - last_cyc, per_exp * tdiv);
        last_cyc = cyc;
        if (!s_lo) begin
          s_word = fw(s_ptr);
          expv = sx8(s_word >> 8) * m_vol;
        end else begin
          expv = sx8(s_word & 255) * m_vol;
          if (s_cnt <= 1) begin s_ptr = m_loc; s_cnt = leff(m_len); end
          else begin s_ptr = (s_ptr + 1) % 262144; s_cnt--; end
          fetch_exp = 1;
        end
        s_lo = !s_lo;
        chk(int'(sample_out) == expv, "R6 R7 sample value", int'(sample_out), expv);
      end
    end
  end

  task automatic run_phase(int lh, int ll, int len, int per, int td, bit bpv,
                           bit sweep, int vol0, int n);
    wr(0, lh); wr(1, ll); wr(2, len); wr(3, per); wr(4, vol0);
    m_loc = (lh % 8) * 32768 + (ll % 32768);
    m_len = len; per_exp = (per < 124) ? 124 : per; tdiv = td; tph = 0; bp = bpv;
    m_vol = veff(vol0);
    q_ptr = m_loc; q_cnt = leff(len); s_ptr = m_loc; s_cnt = leff(len);
    s_lo = 0; last_cyc = -1; nstrb = 0; fetch_exp = 0;
    @(negedge clk); chan_en = 1'b1;
    @(negedge clk);
    chk(mem_req_valid && int'(mem_req_addr) == m_loc, "R2 first request",
        int'(mem_req_addr), m_loc);
    for (int k = 1; k <= n; k++) begin
      while (nstrb < k) @(negedge clk);
      if (sweep) begin
        wr(4, 16'hAA80 | (k % 128));
        m_vol = veff(k % 128);
      end
    end
    @(negedge clk); chan_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(sample_out == 0, "R1 output after disable", int'(sample_out), 0);
    chk(!mem_req_valid, "R1 no request when disabled", int'(mem_req_valid), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(sample_out == 0, "R1 reset output", int'(sample_out), 0);
    chk(!mem_req_valid, "R1 reset request", int'(mem_req_valid), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (mem_req_valid || sample_strobe || sample_out != 0)
        chk(1'b0, "R1 idle activity", int'(sample_out), 0);
    end
    chk(sample_out == 0, "R1 idle output", int'(sample_out), 0);
    // full volume sweep, three-word block
    run_phase(5, 16'h1234, 3, 124, 1, 1'b0, 1'b1, 16'hAA80, 128);
    // top-of-space wrap, clamped period, stalls, forced full scale
    run_phase(7, 16'h7FFE, 5, 5, 1, 1'b1, 1'b0, 16'h017F, 24);
    // one-word block, slow tick, stalls
    run_phase(0, 16'h0100, 1, 300, 2, 1'b1, 1'b0, 16'h0025, 10);
    // zero length counts as one word
    run_phase(2, 16'h7FFF, 0, 130, 1, 1'b0, 1'b0, 16'h003F, 8);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule